// File: doc/BRIEF.md
# Memory-Card Host Interrupt and DMA Request Router

This block holds the pending-event register and the event mask of a memory-card host controller. It turns them into one processor interrupt line and two DMA request lines, one for receive and one for transmit. The controller's command and data engines raise single-cycle set pulses, one per event bit. FIFO accesses and the clock start/stop controls give targeted set and clear pulses. Software writes the mask. A DMA-enable level comes from the command/data configuration.

When DMA is off, every pending bit whose mask bit is clear reaches the interrupt line, and both DMA lines stay low. When DMA is on, the two FIFO service bits leave the interrupt path whatever the mask holds, and drive the DMA request lines instead. The register state is visible on two read-value outputs so the host bus decode can return it.

Pending bit positions: 0 data done, 1 programming done, 2 command done, 3 stop command, 4 clock stopped, 5 receive FIFO service, 6 transmit FIFO service, 7 timer, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 suspend acknowledge.

Top module: `mci_irq_router`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, the pending and mask values read 0 and the three outputs are low.
- R2: A 1 on bit k of `evt_set` in one cycle makes pending bit k read 1 after the next rising clock edge. A pending bit stays 1 until one of its own clear inputs arrives.
- R3: With `dma_en` low, `irq` is 1 exactly when some pending bit has its mask bit at 0.
- R4: A mask write loads bits 12:0 of `mask_wdata` into the mask on the next edge. Bits above 12 are dropped.
- R5: With `dma_en` high, pending bits 5 and 6 never drive `irq`, even when their mask bits are 0. The other bits still follow R3.
- R6: With `dma_en` high, `rx_dma_req` equals pending bit 5 and `tx_dma_req` equals pending bit 6.
- R7: With `dma_en` low, `rx_dma_req` and `tx_dma_req` are both 0.
- R8: A `clk_stop` pulse sets pending bit 4. A `clk_start` pulse alone clears it.
- R9: A `rx_fifo_rd` pulse clears pending bit 5 only. A `tx_fifo_wr` pulse clears pending bit 6 only. No other pending bit changes.
- R10: When a set and a clear reach the same pending bit in the same cycle, the bit ends up 1. This covers `clk_stop` with `clk_start`, and `evt_set` with a FIFO clear.
- R11: A mask write leaves the pending value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_set | input | 13 | One-cycle set pulses, one per pending bit |
| rx_fifo_rd | input | 1 | Receive FIFO was read: clear bit 5 |
| tx_fifo_wr | input | 1 | Transmit FIFO was written: clear bit 6 |
| clk_stop | input | 1 | Card clock stop command: set bit 4 |
| clk_start | input | 1 | Card clock start command: clear bit 4 |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | Mask write data |
| dma_en | input | 1 | DMA enabled by the command/data configuration |
| irq | output | 1 | Processor interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| pend_value | output | 13 | Pending register read value |
| mask_value | output | 13 | Mask register read value |

## Verification
The checker assumes that `dma_en` is a level that the configuration holds. Under that assumption the three outputs are pure functions of the present registers and `dma_en`. The checker also assumes that set and clear pulses last one cycle and do not come back every cycle. Its stability property is therefore conditioned on cycles with no pulse at all.

The stimulus keeps to these assumptions. Every input changes only on the falling edge, each pulse lasts exactly one cycle, and `dma_en` is changed only between table rows. The collision rows deliberately drive a set and a clear to the same bit in one cycle.

// File: rtl/mci_irq_pkg.sv
package mci_irq_pkg;

    localparam int REQ_W       = 13;
    localparam int IDX_CLK_OFF = 4;
    localparam int IDX_RX_SVC  = 5;
    localparam int IDX_TX_SVC  = 6;

    typedef logic [REQ_W-1:0] req_vec_t;

    typedef struct packed {
        req_vec_t set_v;
        req_vec_t clr_v;
    } req_evt_t;

endpackage

// File: rtl/mci_irq_evt_map.sv
module mci_irq_evt_map
    import mci_irq_pkg::*;
#(
    parameter int REQ_W   = mci_irq_pkg::REQ_W,
    parameter int CLK_IDX = mci_irq_pkg::IDX_CLK_OFF,
    parameter int RX_IDX  = mci_irq_pkg::IDX_RX_SVC,
    parameter int TX_IDX  = mci_irq_pkg::IDX_TX_SVC
) (
    input  logic [REQ_W-1:0] evt_set,
    input  logic             rx_fifo_rd,
    input  logic             tx_fifo_wr,
    input  logic             clk_stop,
    input  logic             clk_start,
    output logic [REQ_W-1:0] set_vec,
    output logic [REQ_W-1:0] clr_vec
);

    always_comb begin
        set_vec = evt_set;
        clr_vec = '0;
        for (int b = 0; b < REQ_W; b++) begin
            if (b == CLK_IDX) begin
                set_vec[b] = evt_set[b] | clk_stop;
                clr_vec[b] = clk_start;
            end else if (b == RX_IDX) begin
                clr_vec[b] = rx_fifo_rd;
            end else if (b == TX_IDX) begin
                clr_vec[b] = tx_fifo_wr;
            end
        end
    end

endmodule

// File: rtl/mci_irq_req_reg.sv
module mci_irq_req_reg #(
    parameter int REQ_W = mci_irq_pkg::REQ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] set_vec,
    input  logic [REQ_W-1:0] clr_vec,
    output logic [REQ_W-1:0] pend
);

    typedef struct packed {
        logic [REQ_W-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set is applied after clear so a colliding set survives
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/mci_irq_mask_reg.sv
module mci_irq_mask_reg #(
    parameter int REQ_W = mci_irq_pkg::REQ_W,
    parameter int WR_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WR_W-1:0]  wdata,
    output logic [REQ_W-1:0] mask
);

    typedef struct packed {
        logic [REQ_W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mask = wdata[REQ_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;

endmodule

// File: rtl/mci_irq_route.sv
module mci_irq_route #(
    parameter int REQ_W  = mci_irq_pkg::REQ_W,
    parameter int RX_IDX = mci_irq_pkg::IDX_RX_SVC,
    parameter int TX_IDX = mci_irq_pkg::IDX_TX_SVC
) (
    input  logic [REQ_W-1:0] pend,
    input  logic [REQ_W-1:0] mask,
    input  logic             dma_en,
    output logic             irq,
    output logic             rx_dma_req,
    output logic             tx_dma_req
);

    logic [REQ_W-1:0] svc_bits;
    logic [REQ_W-1:0] eff_mask;

    genvar g;
    generate
        for (g = 0; g < REQ_W; g++) begin : g_svc
            if (g == RX_IDX || g == TX_IDX) begin : g_is_svc
                assign svc_bits[g] = 1'b1;
            end else begin : g_not_svc
                assign svc_bits[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        eff_mask   = dma_en ? (mask | svc_bits) : mask;
        irq        = |(pend & ~eff_mask);
        rx_dma_req = dma_en & pend[RX_IDX];
        tx_dma_req = dma_en & pend[TX_IDX];
    end

endmodule

// File: rtl/mci_irq_router.sv
module mci_irq_router
    import mci_irq_pkg::*;
#(
    parameter int REQ_W = mci_irq_pkg::REQ_W,
    parameter int WR_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] evt_set,
    input  logic             rx_fifo_rd,
    input  logic             tx_fifo_wr,
    input  logic             clk_stop,
    input  logic             clk_start,
    input  logic             mask_we,
    input  logic [WR_W-1:0]  mask_wdata,
    input  logic             dma_en,
    output logic             irq,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic [REQ_W-1:0] pend_value,
    output logic [REQ_W-1:0] mask_value
);

    logic [REQ_W-1:0] set_vec;
    logic [REQ_W-1:0] clr_vec;

    mci_irq_evt_map #(.REQ_W(REQ_W)) u_map (
        .evt_set    (evt_set),
        .rx_fifo_rd (rx_fifo_rd),
        .tx_fifo_wr (tx_fifo_wr),
        .clk_stop   (clk_stop),
        .clk_start  (clk_start),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec)
    );

    mci_irq_req_reg #(.REQ_W(REQ_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend_value)
    );

    mci_irq_mask_reg #(.REQ_W(REQ_W), .WR_W(WR_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (mask_wdata),
        .mask  (mask_value)
    );

    mci_irq_route #(.REQ_W(REQ_W)) u_route (
        .pend       (pend_value),
        .mask       (mask_value),
        .dma_en     (dma_en),
        .irq        (irq),
        .rx_dma_req (rx_dma_req),
        .tx_dma_req (tx_dma_req)
    );

endmodule

// File: rtl/mci_irq_router_chk.sv
module mci_irq_router_chk #(
    parameter int REQ_W = mci_irq_pkg::REQ_W,
    parameter int WR_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REQ_W-1:0] evt_set,
    input logic             rx_fifo_rd,
    input logic             tx_fifo_wr,
    input logic             clk_stop,
    input logic             clk_start,
    input logic             mask_we,
    input logic [WR_W-1:0]  mask_wdata,
    input logic             dma_en,
    input logic             irq,
    input logic             rx_dma_req,
    input logic             tx_dma_req,
    input logic [REQ_W-1:0] pend_value,
    input logic [REQ_W-1:0] mask_value
);
    localparam int RXI = mci_irq_pkg::IDX_RX_SVC;
    localparam int TXI = mci_irq_pkg::IDX_TX_SVC;
    localparam int CKI = mci_irq_pkg::IDX_CLK_OFF;

    logic [REQ_W-1:0] non_svc;
    always_comb begin
        non_svc      = '1;
        non_svc[RXI] = 1'b0;
        non_svc[TXI] = 1'b0;
    end

    // R2 and R11: with no pulse at all, pending does not move
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set == '0 && !rx_fifo_rd && !tx_fifo_wr && !clk_stop && !clk_start)
        |=> $stable(pend_value));

    // R10: a set pulse always lands
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((pend_value & $past(evt_set)) == $past(evt_set)));

    // R8: stop sets the clock-off bit
    a_r8_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |=> pend_value[CKI]);

    // R8: a lone start clears it
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_start && !clk_stop && !evt_set[CKI]) |=> !pend_value[CKI]);

    // R4: mask loads the low bits of the write
    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_value == $past(mask_wdata[REQ_W-1:0])));

    // R7: no DMA requests while DMA is off
    a_r7_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (!rx_dma_req && !tx_dma_req));

    // R6: DMA lines track the service bits
    a_r6_dma_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> (rx_dma_req == pend_value[RXI] && tx_dma_req == pend_value[TXI]));

    // R5: service bits alone never raise irq under DMA
    a_r5_svc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && ((pend_value & ~mask_value & non_svc) == '0)) |-> !irq);

    // R3: without DMA an unmasked pending bit raises irq
    a_r3_unmasked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && ((pend_value & ~mask_value) != '0)) |-> irq);

endmodule

bind mci_irq_router mci_irq_router_chk #(.REQ_W(REQ_W), .WR_W(WR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_set    (evt_set),
    .rx_fifo_rd (rx_fifo_rd),
    .tx_fifo_wr (tx_fifo_wr),
    .clk_stop   (clk_stop),
    .clk_start  (clk_start),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .dma_en     (dma_en),
    .irq        (irq),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req),
    .pend_value (pend_value),
    .mask_value (mask_value)
);

// File: tb/mci_irq_router_bench.sv
`timescale 1ns/1ps
module mci_irq_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt_set = '0;
    logic        rx_fifo_rd = 1'b0;
    logic        tx_fifo_wr = 1'b0;
    logic        clk_stop = 1'b0;
    logic        clk_start = 1'b0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        dma_en = 1'b0;
    logic        irq, rx_dma_req, tx_dma_req;
    logic [12:0] pend_value, mask_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mci_irq_router u_mci_irq_router (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
        .clk_stop(clk_stop), .clk_start(clk_start),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .dma_en(dma_en),
        .irq(irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .pend_value(pend_value), .mask_value(mask_value)
    );

    // row: set13 rxrd txwr stop start mwe mdata16 dma | pend13 mask13 irq rx tx
    localparam int NV = 13;
    localparam logic [63:0] VEC [NV] = '{
        {13'h0001, 5'b00000, 16'h0000, 1'b0, 13'h0001, 13'h0000, 3'b100}, // R2 R3
        {13'h0000, 5'b00001, 16'h0001, 1'b0, 13'h0001, 13'h0001, 3'b000}, // R3 R11
        {13'h0060, 5'b00000, 16'h0000, 1'b0, 13'h0061, 13'h0001, 3'b100}, // R7 R3
        {13'h0000, 5'b00000, 16'h0000, 1'b1, 13'h0061, 13'h0001, 3'b011}, // R5 R6
        {13'h0000, 5'b10000, 16'h0000, 1'b1, 13'h0041, 13'h0001, 3'b001}, // R9 R6
        {13'h0040, 5'b01000, 16'h0000, 1'b1, 13'h0041, 13'h0001, 3'b001}, // R10
        {13'h0000, 5'b01000, 16'h0000, 1'b1, 13'h0001, 13'h0001, 3'b000}, // R9
        {13'h0000, 5'b00100, 16'h0000, 1'b1, 13'h0011, 13'h0001, 3'b100}, // R8 R5
        {13'h0000, 5'b00010, 16'h0000, 1'b1, 13'h0001, 13'h0001, 3'b000}, // R8
        {13'h0000, 5'b00110, 16'h0000, 1'b1, 13'h0011, 13'h0001, 3'b100}, // R10 R8
        {13'h0000, 5'b00001, 16'h1FFF, 1'b0, 13'h0011, 13'h1FFF, 3'b000}, // R4 R3
        {13'h1000, 5'b00000, 16'h0000, 1'b0, 13'h1011, 13'h1FFF, 3'b000}, // R2 R3
        {13'h0000, 5'b00001, 16'h0000, 1'b0, 13'h1011, 13'h0000, 3'b100}  // R3 R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_set = '0; rx_fifo_rd = 0; tx_fifo_wr = 0;
        clk_stop = 0; clk_start = 0; mask_we = 0; mask_wdata = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pend", {19'd0, pend_value}, 32'h0);
        chk("R1 mask", {19'd0, mask_value}, 32'h0);
        chk("R1 outs", {29'd0, irq, rx_dma_req, tx_dma_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            v = VEC[i];
            evt_set    = v[63:51];
            rx_fifo_rd = v[50];
            tx_fifo_wr = v[49];
            clk_stop   = v[48];
            clk_start  = v[47];
            mask_we    = v[46];
            mask_wdata = {16'h0000, v[45:30]};
            dma_en     = v[29];
            @(negedge clk);
            idle_inputs();
            chk($sformatf("R2-table row %0d pend", i), {19'd0, pend_value}, {19'd0, v[28:16]});
            chk($sformatf("R4-table row %0d mask", i), {19'd0, mask_value}, {19'd0, v[15:3]});
            chk($sformatf("R3 R5 R6 R7 row %0d outs", i),
                {29'd0, irq, rx_dma_req, tx_dma_req}, {29'd0, v[2:0]});
        end

        // R4: upper write bits dropped
        mask_we = 1; mask_wdata = 32'hFFFF_E000;
        @(negedge clk);
        idle_inputs();
        chk("R4 upper bits dropped", {19'd0, mask_value}, 32'h0);

        // R9: rx clear with DMA on touches only bit 5
        dma_en = 1;
        evt_set = 13'h0020;
        @(negedge clk);
        idle_inputs();
        chk("R6 rx dma up", {31'd0, rx_dma_req}, 32'h1);
        rx_fifo_rd = 1;
        @(negedge clk);
        idle_inputs();
        chk("R9 only bit5 cleared", {19'd0, pend_value}, 32'h1011);
        chk("R6 rx dma down", {31'd0, rx_dma_req}, 32'h0);

        // R1: reset mid-run clears state
        rst_n = 0;
        @(negedge clk);
        chk("R1 pend after reset", {19'd0, pend_value}, 32'h0);
        chk("R1 outs after reset", {29'd0, irq, rx_dma_req, tx_dma_req}, 32'h0);
        rst_n = 1;
        dma_en = 0;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule